// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This core runs a small integer instruction set and completes every instruction in one clock cycle. Each cycle it sends the program counter to an instruction memory. It decodes the word that comes back, reads up to two operands from a 32-entry register file and computes a result in the ALU. In the same cycle it either writes the result back, performs a data-memory access, or takes a branch. The new program counter, and any register write, take effect on the next rising clock edge.

Both memory ports are combinational. The instruction word and the load data must be valid in the same cycle as the address that requests them. A store is presented as an address, write data and a write strobe, and the memory commits it on the rising edge. The supported operations are five register-to-register operations (add, subtract, and, or, set-on-less-than), a word load, a word store and branch-if-equal. The encoding of any other instruction is treated as a no-op.

Top module: `risc_core`

## Requirements
- R1: While `rst` is high, the program counter is cleared to 0 on each rising edge, so `imem_addr` reads 0 from the cycle after a reset edge. Every register-file entry is cleared at the same time.
- R2: Any instruction that does not take a branch advances `imem_addr` by exactly 4 on the next rising edge. `imem_addr` is always a multiple of 4.
- R3: An instruction with opcode bits [31:26] equal to 0 is a register operation. Its sources are the registers in bits [25:21] and [20:16], its destination is the register in bits [15:11], and bits [5:0] select the operation: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or, 0x2A set-on-less-than.
- R4: Set-on-less-than writes 1 when bit 31 of (first source − second source) is 1, and writes 0 otherwise.
- R5: A load (opcode 0x23) reads data memory at the address (register [25:21] + sign-extended bits [15:0]) and writes the read data into register [20:16]. Negative offsets work.
- R6: A store (opcode 0x2B) drives that same address on `dmem_addr`, drives register [20:16] on `dmem_wdata`, raises `dmem_we`, and changes no register.
- R7: Branch-if-equal (opcode 0x04) compares registers [25:21] and [20:16]. When they are equal, the next PC is PC + 4 + (sign-extended immediate × 4), and backward targets are allowed. When they differ, the next PC is PC + 4.
- R8: Register 0 always reads as zero. A write aimed at register 0 has no effect.
- R9: An unsupported opcode, or an unsupported function code under opcode 0, writes no register, performs no store, and advances the PC by 4.
- R10: `dmem_we` is low during every cycle whose instruction is not a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Program counter, the byte address of the current instruction |
| imem_data | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Data to store |
| dmem_we | output | 1 | Store strobe, committed by memory on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The assertions assume that `imem_data` is a defined word decoded from the current `imem_addr`, and that the data memory answers combinationally. They also assume that reset is held for at least one rising edge before the first checked cycle. The bench meets these assumptions with array-backed memories that are indexed directly by the core's address outputs. Unused instruction slots are filled with the all-zero word, which decodes as an unsupported function code and therefore as a no-op. Each program ends either in that no-op region or in a branch to itself. Operand values are chosen so that no subtraction overflows, which keeps the expected set-on-less-than results the same as a signed comparison.

// File: rtl/risc_pkg.sv
package risc_pkg;

    localparam int INSN_W  = 32;
    localparam int OP_W    = 6;
    localparam int RIDX_W  = 5;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;

    localparam int OP_HI   = 31;
    localparam int RS_HI   = 25;
    localparam int RT_HI   = 20;
    localparam int RD_HI   = 15;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_AND  = 3'b000,
        ALU_OR   = 3'b001,
        ALU_ADD  = 3'b010,
        ALU_SUB  = 3'b110,
        ALU_SLT  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    src_is_imm;
        logic    mem_write;
        logic    load_result;
        logic    branch_eq;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] shamt;
        logic [FN_W-1:0]   funct;
    } insn_fields_t;

    localparam ctrl_t CTRL_NOP = '{
        reg_write:   1'b0,
        dst_is_rd:   1'b0,
        src_is_imm:  1'b0,
        mem_write:   1'b0,
        load_result: 1'b0,
        branch_eq:   1'b0,
        alu_op:      ALU_ADD
    };

    function automatic insn_fields_t split_insn(input logic [INSN_W-1:0] w);
        insn_fields_t f;
        f = w;
        return f;
    endfunction

    function automatic logic [31:0] widen_imm(input logic [IMM_W-1:0] imm);
        return {{(32-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

endpackage

// File: rtl/risc_decode.sv
module risc_decode
    import risc_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  logic [FN_W-1:0] funct,
    output ctrl_t           ctrl
);

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_write   = 1'b1;
                ctrl.src_is_imm  = 1'b1;
                ctrl.load_result = 1'b1;
                ctrl.alu_op      = ALU_ADD;
            end
            OPC_STORE: begin
                ctrl.mem_write  = 1'b1;
                ctrl.src_is_imm = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl.branch_eq = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ctrl = CTRL_NOP;
        endcase
    end

endmodule

// File: rtl/risc_regfile.sv
module risc_regfile #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx_a,
    output logic [DATA_W-1:0] rd_val_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_val_b,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_val
);

    logic [DATA_W-1:0] cells [ENTRIES];

    // Entry 0 is never stored; the generate covers the writable entries only.
    assign cells[0] = '0;

    for (genvar gi = 1; gi < ENTRIES; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                cells[gi] <= wr_val;
            end
        end
    end

    assign rd_val_a = cells[rd_idx_a];
    assign rd_val_b = cells[rd_idx_b];

endmodule

// File: rtl/risc_alu.sv
module risc_alu
    import risc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);

    logic              invert_b;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum;

    // The top bit of the op code turns the adder into a subtracter.
    assign invert_b = op[2];
    assign b_eff    = invert_b ? ~opb : opb;
    assign sum      = opa + b_eff + DATA_W'(invert_b);

    always_comb begin
        unique case (op)
            ALU_AND: result = opa & opb;
            ALU_OR:  result = opa | opb;
            ALU_ADD: result = sum;
            ALU_SUB: result = sum;
            ALU_SLT: result = {{(DATA_W-1){1'b0}}, sum[DATA_W-1]};
            default: result = sum;
        endcase
    end

    assign is_zero = (result == '0);

endmodule

// File: rtl/risc_core.sv
module risc_core
    import risc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_REGS = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0]      pc_q;
    logic [XLEN-1:0]      pc_seq;
    logic [XLEN-1:0]      pc_jump;
    logic [XLEN-1:0]      pc_d;
    insn_fields_t         fld;
    ctrl_t                ctrl;
    logic [XLEN-1:0]      imm_ext;
    logic [XLEN-1:0]      src_a;
    logic [XLEN-1:0]      src_b;
    logic [XLEN-1:0]      alu_b;
    logic [XLEN-1:0]      alu_y;
    logic                 alu_zero;
    logic                 take_branch;
    logic                 wb_en;
    logic [REG_IDX_W-1:0] wb_idx;
    logic [XLEN-1:0]      wb_val;

    assign fld     = split_insn(imem_data);
    assign imm_ext = XLEN'(signed'(widen_imm(imem_data[IMM_W-1:0])));

    risc_decode u_decode (
        .opcode (fld.opcode),
        .funct  (fld.funct),
        .ctrl   (ctrl)
    );

    risc_regfile #(
        .DATA_W  (XLEN),
        .ENTRIES (NUM_REGS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (REG_IDX_W'(fld.rs)),
        .rd_val_a (src_a),
        .rd_idx_b (REG_IDX_W'(fld.rt)),
        .rd_val_b (src_b),
        .wr_en    (wb_en),
        .wr_idx   (wb_idx),
        .wr_val   (wb_val)
    );

    assign alu_b = ctrl.src_is_imm ? imm_ext : src_b;

    risc_alu #(
        .DATA_W (XLEN)
    ) u_alu (
        .opa     (src_a),
        .opb     (alu_b),
        .op      (ctrl.alu_op),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    assign wb_en  = ctrl.reg_write;
    assign wb_idx = REG_IDX_W'(ctrl.dst_is_rd ? fld.rd : fld.rt);
    assign wb_val = ctrl.load_result ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = src_b;
    assign dmem_we    = ctrl.mem_write;

    assign pc_seq      = pc_q + STEP;
    assign pc_jump     = pc_seq + (imm_ext << 2);
    assign take_branch = ctrl.branch_eq && alu_zero;
    assign pc_d        = take_branch ? pc_jump : pc_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign imem_addr = pc_q;

endmodule

// File: rtl/risc_core_chk.sv
module risc_core_chk
    import risc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic        wb_en
);

    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;
    logic            fn_known;
    logic            op_known;

    assign opc      = imem_data[31:26];
    assign fn       = imem_data[5:0];
    assign fn_known = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                      (fn == FN_OR)  || (fn == FN_SLT);
    assign op_known = ((opc == OPC_RTYPE) && fn_known) || (opc == OPC_LOAD) ||
                      (opc == OPC_STORE) || (opc == OPC_BEQ);

    // R1
    pc_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == 32'h0));

    // R2
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        imem_addr[1:0] == 2'b00);

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BEQ) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R10
    store_only_we_chk: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opc == OPC_STORE));

    // R9
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !op_known |-> (!dmem_we && !wb_en));

endmodule

bind risc_core risc_core_chk u_risc_core_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .wb_en     (wb_en)
);

// File: tb/risc_core_bench.sv
module risc_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int          checks = 0;
    int          errors = 0;
    int          we_count = 0;

    always #2.5 clk = ~clk;

    risc_core u_risc_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (dmem_we) begin
            dmem[dmem_addr[7:2]] <= dmem_wdata;
            we_count <= we_count + 1;
        end
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h0;
        end
    endtask

    task automatic start_run(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        we_count = 0;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        clear_mem();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 pc held at zero in reset", imem_addr, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R2 pc step after reset", imem_addr, 32'h4);
        @(posedge clk);
        @(negedge clk);
        check("R2 pc second step", imem_addr, 32'h8);
    endtask

    task automatic test_alu();
        clear_mem();
        dmem[0] = 32'd25;
        dmem[1] = 32'd32;
        dmem[2] = 32'hF0F0_00FF;
        dmem[3] = 32'h0FF0_0F0F;
        imem[0]  = enc_i(6'h23, 0, 1, 0);
        imem[1]  = enc_i(6'h23, 0, 2, 4);
        imem[2]  = enc_i(6'h23, 0, 3, 8);
        imem[3]  = enc_i(6'h23, 0, 4, 12);
        imem[4]  = enc_r(6'h20, 1, 2, 5);
        imem[5]  = enc_r(6'h22, 1, 2, 6);
        imem[6]  = enc_r(6'h24, 3, 4, 7);
        imem[7]  = enc_r(6'h25, 3, 4, 8);
        imem[8]  = enc_r(6'h2A, 1, 2, 9);
        imem[9]  = enc_r(6'h2A, 2, 1, 10);
        for (int k = 0; k < 6; k++) begin
            imem[10+k] = enc_i(6'h2B, 0, 5 + k, 16 + 4*k);
        end
        start_run(24);
        check("R3 add", dmem[4], 32'd57);
        check("R3 sub", dmem[5], 32'hFFFF_FFF9);
        check("R3 and", dmem[6], 32'h00F0_000F);
        check("R3 or", dmem[7], 32'hFFF0_0FFF);
        check("R4 slt less", dmem[8], 32'd1);
        check("R4 slt not less", dmem[9], 32'd0);
    endtask

    task automatic test_mem_offsets();
        clear_mem();
        dmem[0] = 32'd40;
        dmem[9] = 32'h1234_5678;
        imem[0] = enc_i(6'h23, 0, 1, 0);
        imem[1] = enc_i(6'h23, 1, 2, -4);
        imem[2] = enc_i(6'h2B, 1, 2, 8);
        start_run(8);
        check("R5 load with negative offset", dmem[12], 32'h1234_5678);
        check("R6 single store strobe", 32'(we_count), 32'd1);
    endtask

    task automatic test_zero_and_unknown();
        clear_mem();
        dmem[0] = 32'd7;
        dmem[1] = 32'hDEAD_BEEF;
        dmem[5] = 32'h0000_FFFF;
        dmem[6] = 32'h0000_FFFF;
        imem[0] = enc_i(6'h23, 0, 0, 4);
        imem[1] = enc_r(6'h25, 0, 0, 0);
        imem[2] = enc_i(6'h2B, 0, 0, 20);
        imem[3] = enc_i(6'h23, 0, 1, 0);
        imem[4] = enc_i(6'h08, 0, 1, 99);
        imem[5] = enc_r(6'h21, 1, 1, 1);
        imem[6] = enc_i(6'h3F, 0, 1, 0);
        imem[7] = enc_i(6'h2B, 0, 1, 24);
        start_run(14);
        check("R8 register 0 stays zero", dmem[5], 32'h0);
        check("R9 unsupported codes leave r1", dmem[6], 32'd7);
        check("R10 strobe only on stores", 32'(we_count), 32'd2);
    endtask

    task automatic test_branch();
        clear_mem();
        dmem[0] = 32'd5;
        dmem[1] = 32'd5;
        dmem[2] = 32'd6;
        dmem[4] = 32'h0000_AAAA;
        dmem[5] = 32'h0000_AAAA;
        imem[0] = enc_i(6'h23, 0, 1, 0);
        imem[1] = enc_i(6'h23, 0, 2, 4);
        imem[2] = enc_i(6'h23, 0, 3, 8);
        imem[3] = enc_i(6'h04, 1, 2, 2);
        imem[4] = enc_i(6'h2B, 0, 1, 16);
        imem[5] = enc_i(6'h2B, 0, 1, 20);
        imem[6] = enc_i(6'h04, 1, 3, 5);
        imem[7] = enc_i(6'h2B, 0, 3, 24);
        imem[8] = enc_i(6'h04, 0, 0, -1);
        start_run(20);
        check("R7 taken branch skips store a", dmem[4], 32'h0000_AAAA);
        check("R7 taken branch skips store b", dmem[5], 32'h0000_AAAA);
        check("R7 untaken branch falls through", dmem[6], 32'd6);
        check("R7 backward branch holds pc", imem_addr, 32'd32);
        @(posedge clk);
        @(negedge clk);
        check("R7 backward branch stays", imem_addr, 32'd32);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        test_reset();
        test_alu();
        test_mem_offsets();
        test_zero_and_unknown();
        test_branch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule